// File: doc/BRIEF.md
# Coprocessor Status and Control Register

This block is the host-visible run control of a signal-processing coprocessor. The host writes 32-bit command words to it. In a command word, each status flag owns a two-bit field. The low bit of the field requests a clear and the high bit requests a set. A field with both bits equal does nothing. The block keeps these flags:

- halt
- broke
- single-step
- interrupt-on-break
- a bank of general signal bits

It drives an interrupt request toward the host interrupt controller. When a write releases the processor, it raises a one-cycle start pulse.

A second register holds the processor's program counter. This register keeps only the word-aligned bits inside the local memory window. Every other bit is forced to zero on write and on read. The core reports a break through a single input. That input sets broke, and it also raises the interrupt when interrupt-on-break is enabled.

Both registers share one write port, selected by `wr_addr`: 0 selects status/command and 1 selects the program counter. The read port `rd_addr` uses the same coding. Read data is combinational from the held state.

Top module: `cop_status_ctl`

## Requirements
- R1: While the synchronous, active-high `rst` is held, the next edge sets halt and clears every other flag, the interrupt, the start pulse and the program counter. The status read then returns 0x00000001.
- R2: A status write (`wr_addr`=0) acts on halt through `wr_data[1:0]`. A value of 01 clears halt, 10 sets it, and 00 or 11 leave it unchanged.
- R3: Bit 2 of a status write clears broke. A `core_break` edge sets broke, and this set wins over a clear in the same cycle. No write value can set broke.
- R4: `wr_data[4:3]` of a status write acts on `irq`. A value of 01 deasserts it, 10 asserts it, and 00 or 11 leave it unchanged.
- R5: Single-step uses `wr_data[6:5]` and interrupt-on-break uses `wr_data[8:7]`. Both follow the rule 01 = clear, 10 = set, otherwise hold.
- R6: Signal flag n (0..7) is driven by `wr_data[10+2n:9+2n]` under the same pair rule. Signal 7 therefore uses bits [24:23].
- R7: A `core_break` edge asserts `irq` on the same edge that sets broke, but only if interrupt-on-break was held set before that edge. This overrides an `irq` deassert requested in the same cycle.
- R8: `start` is high for exactly the cycle after a status write that meets two conditions. First, the write either has `wr_data[1:0]`=01 or has bit 2 set. Second, halt is clear after that write's update. A set broke flag does not prevent the pulse.
- R9: A write with `wr_addr`=1 stores only `wr_data[11:2]` into the program counter. A read with `rd_addr`=1 returns those bits, with all other bits zero. A program-counter write leaves the status flags unchanged.
- R10: A status read (`rd_addr`=0) places halt at bit 0, broke at bit 1, single-step at bit 5, interrupt-on-break at bit 6 and signal n at bit 7+n. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one word |
| wr_addr | input | 1 | Write target: 0 status/command, 1 program counter |
| wr_data | input | 32 | Command word or program counter value |
| core_break | input | 1 | Break event from the processor core |
| rd_addr | input | 1 | Read target: 0 status, 1 program counter |
| rd_data | output | 32 | Read data for `rd_addr` |
| irq | output | 1 | Interrupt request to the host controller |
| start | output | 1 | One-cycle pulse to begin processor execution |

## Verification
The bench builds the block with its defaults: eight signal flags, a 12-bit program counter window and 32-bit words. With these values the highest command pair (bits [24:23]) and the top kept counter bit (bit 11) sit right at the edges the requirements name. Directed sequences cover several combinations:

- halt released with broke still set
- a broke clear that coexists with a halt set
- a break arriving with an interrupt deassert in the same cycle
- both-bits-set pairs on every flag

A long pseudo-random phase follows. It mixes writes to both registers with break events. A behavioural model checks status, counter, interrupt and start on every cycle.

// File: rtl/cop_status_ctl.sv
module cop_status_ctl #(
  parameter int DW   = 32,
  parameter int NSIG = 8,
  parameter int PCW  = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          core_break,
  input  logic          rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          start
);
  localparam int SIG_CMD = 9;
  localparam int SIG_RD  = 7;
  localparam logic [DW-1:0] PC_MASK = {{(DW-PCW){1'b0}}, {(PCW-2){1'b1}}, 2'b00};

  logic            halt_q, broke_q, sstep_q, ibrk_q;
  logic [NSIG-1:0] sig_q;
  logic [DW-1:0]   pc_q;
  logic [DW-1:0]   stat;
  logic            halt_d, go;

  function automatic logic pair_next(input logic cur, input logic [1:0] f);
    case (f)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  wire cmd = wr_en && !wr_addr;
  wire pcw = wr_en && wr_addr;

  assign halt_d = cmd ? pair_next(halt_q, wr_data[1:0]) : halt_q;
  assign go     = cmd && ((wr_data[1:0] == 2'b01) || wr_data[2]) && !halt_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q  <= 1'b1;
      broke_q <= 1'b0;
      sstep_q <= 1'b0;
      ibrk_q  <= 1'b0;
      irq     <= 1'b0;
      start   <= 1'b0;
      pc_q    <= '0;
    end else begin
      halt_q <= halt_d;
      start  <= go;
      if (core_break)
        broke_q <= 1'b1;
      else if (cmd && wr_data[2])
        broke_q <= 1'b0;
      if (cmd) begin
        sstep_q <= pair_next(sstep_q, wr_data[6:5]);
        ibrk_q  <= pair_next(ibrk_q, wr_data[8:7]);
      end
      if (core_break && ibrk_q)
        irq <= 1'b1;
      else if (cmd)
        irq <= pair_next(irq, wr_data[4:3]);
      if (pcw)
        pc_q <= wr_data & PC_MASK;
    end
  end

  for (genvar n = 0; n < NSIG; n++) begin : g_sig
    always_ff @(posedge clk) begin
      if (rst)
        sig_q[n] <= 1'b0;
      else if (cmd)
        sig_q[n] <= pair_next(sig_q[n], wr_data[SIG_CMD+2*n +: 2]);
    end
  end

  always_comb begin
    stat = '0;
    stat[0] = halt_q;
    stat[1] = broke_q;
    stat[5] = sstep_q;
    stat[6] = ibrk_q;
    stat[SIG_RD +: NSIG] = sig_q;
  end

  assign rd_data = rd_addr ? (pc_q & PC_MASK) : stat;
endmodule

module cop_status_ctl_chk #(
  parameter int DW  = 32,
  parameter int PCW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          core_break,
  input logic          halt_q,
  input logic          broke_q,
  input logic          irq,
  input logic          start,
  input logic [DW-1:0] pc_q
);
  p_halt_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr && wr_data[1:0] == 2'b01) |=> !halt_q);
  p_halt_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr && wr_data[1:0] == 2'b11) |=> $stable(halt_q));
  p_broke_source_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(broke_q) |-> $past(core_break));
  p_irq_source_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(core_break || (wr_en && !wr_addr && wr_data[4:3] == 2'b10)));
  p_start_running_r8: assert property (@(posedge clk) disable iff (rst)
    start |-> !halt_q);
  p_start_cause_r8: assert property (@(posedge clk) disable iff (rst)
    start |-> $past(wr_en && !wr_addr && (wr_data[1:0] == 2'b01 || wr_data[2])));
  p_pc_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    (pc_q[1:0] == 2'b00) && (pc_q[DW-1:PCW] == '0));
endmodule

bind cop_status_ctl cop_status_ctl_chk #(.DW(DW), .PCW(PCW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .core_break(core_break), .halt_q(halt_q), .broke_q(broke_q), .irq(irq),
  .start(start), .pc_q(pc_q));

// File: tb/cop_status_ctl_bench.sv
module cop_status_ctl_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, wr_addr = 1'b0, core_break = 1'b0, rd_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq, start;
  int vectors = 0, miscompares = 0;

  bit m_halt = 1, m_broke = 0, m_sstep = 0, m_ibrk = 0, m_irq = 0, m_start = 0;
  bit [7:0] m_sig = '0;
  bit [31:0] m_pc = '0;

  always #5 clk = ~clk;

  cop_status_ctl u_cop_status_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .core_break(core_break), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .start(start));

  function automatic bit pn(bit c, bit [1:0] f);
    if (f == 2'b01) return 1'b0;
    if (f == 2'b10) return 1'b1;
    return c;
  endfunction

  function automatic bit [31:0] exp_rd(bit ra);
    bit [31:0] v = '0;
    if (ra) return m_pc;
    v[0] = m_halt; v[1] = m_broke; v[5] = m_sstep; v[6] = m_ibrk;
    for (int n = 0; n < 8; n++) v[7+n] = m_sig[n];
    return v;
  endfunction

  task automatic step(input bit we, input bit a, input bit [31:0] d,
                      input bit brk, input bit ra, input string tag);
    bit c, nh;
    bit [31:0] e;
    c = we && !a;
    wr_en = we; wr_addr = a; wr_data = d; core_break = brk; rd_addr = ra;
    nh = c ? pn(m_halt, d[1:0]) : m_halt;
    m_start = c && (d[1:0] == 2'b01 || d[2]) && !nh;
    if (brk && m_ibrk) m_irq = 1;
    else if (c) m_irq = pn(m_irq, d[4:3]);
    if (brk) m_broke = 1;
    else if (c && d[2]) m_broke = 0;
    m_halt = nh;
    if (c) begin
      m_sstep = pn(m_sstep, d[6:5]);
      m_ibrk  = pn(m_ibrk, d[8:7]);
      for (int n = 0; n < 8; n++) m_sig[n] = pn(m_sig[n], d[10+2*n -: 2]);
    end
    if (we && a) m_pc = d & 32'h0000_0FFC;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; core_break = 0;
    vectors++;
    e = exp_rd(ra);
    if (rd_data !== e) begin
      miscompares++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, e);
    end
    if (irq !== m_irq) begin
      miscompares++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, m_irq);
    end
    if (start !== m_start) begin
      miscompares++;
      $display("FAIL %s start actual=%b expected=%b", tag, start, m_start);
    end
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    bit [31:0] lf = 32'h1357_9BDF;
    repeat (3) @(negedge clk);
    rst = 0;
    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 1, "R1");
    // R2 and R8: release halt, then set, hold with 11 and 00
    step(1, 0, 32'h1, 0, 0, "R2");
    step(1, 0, 32'h2, 0, 0, "R2");
    step(1, 0, 32'h3, 0, 0, "R2");
    step(1, 0, 32'h0, 0, 0, "R2");
    // R3: break sets broke, clear, break beats clear
    step(0, 0, 0, 1, 0, "R3");
    step(1, 0, 32'h4, 0, 0, "R3");
    step(1, 0, 32'h4, 1, 0, "R3");
    step(1, 0, 32'hFFFF_FFFB, 0, 0, "R3");
    // R4: irq pair
    step(1, 0, 32'h10, 0, 0, "R4");
    step(1, 0, 32'h18, 0, 0, "R4");
    step(1, 0, 32'h08, 0, 0, "R4");
    // R5: single-step and interrupt-on-break
    step(1, 0, 32'h40, 0, 0, "R5");
    step(1, 0, 32'h60, 0, 0, "R5");
    step(1, 0, 32'h20, 0, 0, "R5");
    step(1, 0, 32'h100, 0, 0, "R5");
    step(1, 0, 32'h180, 0, 0, "R5");
    // R6: each signal set, hold, clear
    for (int n = 0; n < 8; n++) step(1, 0, 32'h1 << (10+2*n), 0, 0, "R6");
    for (int n = 0; n < 8; n++) step(1, 0, 32'h3 << (9+2*n), 0, 0, "R6");
    for (int n = 0; n < 8; n += 2) step(1, 0, 32'h1 << (9+2*n), 0, 0, "R6");
    // R7: break with interrupt-on-break set, also against a deassert
    step(0, 0, 0, 1, 0, "R7");
    step(1, 0, 32'h08, 0, 0, "R7");
    step(1, 0, 32'h08, 1, 0, "R7");
    step(1, 0, 32'h88, 0, 0, "R7");
    step(0, 0, 0, 1, 0, "R7");
    // R8: start cases, broke set does not block
    step(1, 0, 32'h1, 0, 0, "R8");
    step(1, 0, 32'h4, 0, 0, "R8");
    step(1, 0, 32'h0, 0, 0, "R8");
    step(1, 0, 32'h3, 0, 0, "R8");
    step(1, 0, 32'h1, 1, 0, "R8");
    step(1, 0, 32'h6, 0, 0, "R8");
    step(1, 0, 32'h5, 0, 0, "R8");
    // R9: program counter masking, status unaffected
    step(1, 1, 32'hFFFF_FFFF, 0, 1, "R9");
    step(1, 1, 32'h0000_0123, 0, 1, "R9");
    step(1, 1, 32'h0000_1003, 0, 0, "R9");
    step(0, 0, 0, 0, 1, "R9");
    // R10: mixed traffic
    for (int i = 0; i < 600; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(lf[27], lf[29], lf, lf[30] & lf[26], lf[28], "R10");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule